// File: doc/BRIEF.md
# Sleep and Watchdog Interval Timer

This block runs from the 32 kHz low-speed clock. A free-running counter produces a periodic wake tick, with the interval picked by a 2-bit code: 64, 512, 4096 or 32,768 low-speed cycles. Software writes the code through a small write port. A new code takes effect only when the running interval ends, so a shortened or runt tick cannot occur.

The watchdog has no counter of its own. It counts wake ticks, and if three ticks go by with no clear strobe from software, it emits a system reset pulse of fixed length. The nominal watchdog period is therefore three sleep intervals.

While the device sleeps, the block also asks for the bandgap reference. With the no-buzz flag set, it holds that request high. With the flag clear, it requests the bandgap only in short bursts from a separate duty counter, whose rate does not depend on the sleep interval. While the device is awake, the request stays high.

Top module: `sleep_wdt_timer`

## Requirements
- R1: The interval code sets the tick-to-tick distance. Code 2'b00 gives 64 cycles, 2'b01 gives 512, 2'b10 gives 4096 and 2'b11 gives 32,768.
- R2: After reset the interval code is 2'b00, and sleep_tick_o and wdt_reset_o are low. The first tick appears 64 edges after reset is released.
- R3: sleep_tick_o is high for exactly one clock cycle per interval.
- R4: A code written while an interval is running leaves that interval's length unchanged. The new length applies from the interval that follows.
- R5: If three ticks pass with no clear since the last clear or fire, wdt_reset_o rises in the cycle after the third tick. It never rises at any other time.
- R6: A clear sets the tick tally back to zero. A clear in the same cycle as a tick wins, and that tick is not counted.
- R7: wdt_reset_o stays high for RST_HOLD cycles (default 4) and then goes low.
- R8: bandgap_en_o is high whenever sleep_active_i is low.
- R9: bandgap_en_o is high continuously while sleep_active_i and no_buzz_i are both high.
- R10: While sleeping with no_buzz_i low, bandgap_en_o follows a free-running duty counter started at reset. After j edges since reset, the output is high when (j mod (BG_ON+BG_OFF)) < BG_ON (defaults 2 and 14). The pattern does not depend on the interval code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32 kHz low-speed clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the interval code |
| cfg_sel_i | input | 2 | Interval code to be written |
| wdt_clear_i | input | 1 | Watchdog service strobe |
| sleep_active_i | input | 1 | Device is in sleep |
| no_buzz_i | input | 1 | Keep the bandgap on for the whole of sleep |
| sleep_tick_o | output | 1 | Single-cycle wake tick |
| wdt_reset_o | output | 1 | Watchdog system reset pulse |
| bandgap_en_o | output | 1 | Bandgap enable request |

## Verification
A service clear and a wake tick can arrive in the same cycle. That is the one point where the watchdog tally must choose which input wins. The bench drives the clear strobe during exactly the cycle in which the third tick is visible on the port. It then expects no reset pulse. It also expects that two further ticks still produce no pulse, and that the third one does. A code write landing mid-interval is a second overlap, this time between configuration and the terminal count. It is judged by the length of the interval in progress.

// File: rtl/sleep_wdt_pkg.sv
package sleep_wdt_pkg;
  localparam int SEL_W    = 2;
  localparam int BASE_LOG = 6;  // code 0 period = 2**6
  localparam int STEP_LOG = 3;  // each code step multiplies period by 8
  localparam int CNT_W    = BASE_LOG + STEP_LOG * ((1 << SEL_W) - 1);

  function automatic logic [CNT_W-1:0] term_of(input logic [SEL_W-1:0] sel);
    logic [CNT_W:0] one_hot;
    one_hot = (CNT_W+1)'(1) << (BASE_LOG + STEP_LOG * int'(sel));
    return CNT_W'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/interval_counter.sv
module interval_counter
  import sleep_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  output logic             tick_o
);
  logic [SEL_W-1:0] sel_pend_q, sel_act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;
  logic             wrap;

  assign wrap = (cnt_q == term_of(sel_act_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_pend_q <= '0;
      sel_act_q  <= '0;
      cnt_q      <= '0;
      tick_q     <= 1'b0;
    end else begin
      if (cfg_we_i) sel_pend_q <= cfg_sel_i;
      if (wrap) begin
        cnt_q     <= '0;
        sel_act_q <= sel_pend_q;  // new code only at interval boundary
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      tick_q <= wrap;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/wdt_tally.sv
module wdt_tally #(
  parameter int TICKS    = 3,
  parameter int RST_HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic wdt_o
);
  localparam int TALLY_W = $clog2(TICKS + 1);
  localparam int HOLD_W  = $clog2(RST_HOLD + 1);

  logic [TALLY_W-1:0] tally_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               fire;

  assign fire = !clear_i && tick_i && (tally_q == TALLY_W'(TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tally_q <= '0;
    end else if (clear_i) begin
      tally_q <= '0;  // service wins over a coincident tick
    end else if (tick_i) begin
      tally_q <= fire ? '0 : tally_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (fire) begin
      hold_q <= HOLD_W'(RST_HOLD);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  assign wdt_o = (hold_q != '0);
endmodule

// File: rtl/bandgap_duty.sv
module bandgap_duty #(
  parameter int BG_ON  = 2,
  parameter int BG_OFF = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  input  logic no_buzz_i,
  output logic bg_en_o
);
  localparam int PERIOD = BG_ON + BG_OFF;
  localparam int DC_W   = $clog2(PERIOD);

  logic [DC_W-1:0] dc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_q <= '0;
    end else if (dc_q == DC_W'(PERIOD - 1)) begin
      dc_q <= '0;
    end else begin
      dc_q <= dc_q + 1'b1;
    end
  end

  assign bg_en_o = !sleep_i || no_buzz_i || (dc_q < DC_W'(BG_ON));
endmodule

// File: rtl/sleep_wdt_timer.sv
module sleep_wdt_timer
  import sleep_wdt_pkg::*;
#(
  parameter int WDT_TICKS = 3,
  parameter int RST_HOLD  = 4,
  parameter int BG_ON     = 2,
  parameter int BG_OFF    = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_sel_i,
  input  logic       wdt_clear_i,
  input  logic       sleep_active_i,
  input  logic       no_buzz_i,
  output logic       sleep_tick_o,
  output logic       wdt_reset_o,
  output logic       bandgap_en_o
);
  logic tick;

  interval_counter i_interval (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_we_i (cfg_we_i),
    .cfg_sel_i(cfg_sel_i),
    .tick_o   (tick)
  );

  wdt_tally #(
    .TICKS   (WDT_TICKS),
    .RST_HOLD(RST_HOLD)
  ) i_wdt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .clear_i(wdt_clear_i),
    .wdt_o  (wdt_reset_o)
  );

  bandgap_duty #(
    .BG_ON (BG_ON),
    .BG_OFF(BG_OFF)
  ) i_bg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_i  (sleep_active_i),
    .no_buzz_i(no_buzz_i),
    .bg_en_o  (bandgap_en_o)
  );

  assign sleep_tick_o = tick;
endmodule

// File: rtl/sleep_wdt_checker.sv
module sleep_wdt_checker #(
  parameter int RST_HOLD = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wdt_clear_i,
  input logic sleep_active_i,
  input logic no_buzz_i,
  input logic sleep_tick_o,
  input logic wdt_reset_o,
  input logic bandgap_en_o
);
  logic [16:0] gap_q;
  logic        seen_q;
  logic [7:0]  run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      if (sleep_tick_o) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
      run_q <= wdt_reset_o ? run_q + 1'b1 : '0;
    end
  end

  a_r1_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_tick_o && seen_q) |-> ((gap_q + 17'd1 == 17'd64) || (gap_q + 17'd1 == 17'd512) ||
                                  (gap_q + 17'd1 == 17'd4096) || (gap_q + 17'd1 == 17'd32768)));

  a_r3_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_tick_o |=> !sleep_tick_o);

  a_r5_fire_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_reset_o) |-> $past(sleep_tick_o));

  a_r6_clear_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clear_i |=> !$rose(wdt_reset_o));

  a_r7_hold_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_reset_o |-> (run_q < 8'(RST_HOLD)));

  a_r7_hold_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_reset_o) |-> (run_q == 8'(RST_HOLD)));

  a_r8_awake_bg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_active_i |-> bandgap_en_o);

  a_r9_no_buzz_bg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_active_i && no_buzz_i) |-> bandgap_en_o);
endmodule

bind sleep_wdt_timer sleep_wdt_checker #(.RST_HOLD(RST_HOLD)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wdt_clear_i   (wdt_clear_i),
  .sleep_active_i(sleep_active_i),
  .no_buzz_i     (no_buzz_i),
  .sleep_tick_o  (sleep_tick_o),
  .wdt_reset_o   (wdt_reset_o),
  .bandgap_en_o  (bandgap_en_o)
);

// File: tb/test_sleep_wdt_timer.sv
module test_sleep_wdt_timer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'b00;
  logic       wdt_clear = 1'b0;
  logic       sleep_active = 1'b0;
  logic       no_buzz = 1'b0;
  logic       tick, wdt, bg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam int NV = 4;
  localparam logic [1:0] VSEL [NV] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam int         VGAP [NV] = '{64, 512, 4096, 32768};

  always #5 clk = ~clk;

  sleep_wdt_timer i_sleep_wdt_timer (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we),
    .cfg_sel_i     (cfg_sel),
    .wdt_clear_i   (wdt_clear),
    .sleep_active_i(sleep_active),
    .no_buzz_i     (no_buzz),
    .sleep_tick_o  (tick),
    .wdt_reset_o   (wdt),
    .bandgap_en_o  (bg)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; cfg_we = 1'b0; wdt_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // counts negedges until tick seen high; flags any wdt pulse seen on the way
  task automatic wait_tick(output int n, output bit wdt_seen);
    n = 0; wdt_seen = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (wdt) wdt_seen = 1'b1;
    end while (!tick && n < 40000);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    summary();
  end

  initial begin
    int n;
    bit ws;

    // R2 / R8: reset state
    do_reset();
    check(tick == 1'b0, "R2 tick after reset", int'(tick), 0);
    check(wdt == 1'b0, "R2 wdt after reset", int'(wdt), 0);
    check(bg == 1'b1, "R8 bandgap awake", int'(bg), 1);
    wait_tick(n, ws);
    check(n == 64, "R2 first tick default code", n, 64);
    wait_tick(n, ws);
    check(n == 64, "R2 default period", n, 64);

    // R1 / R3 / R4: vector table walk
    for (int v = 0; v < NV; v++) begin
      do_reset();
      cfg_we = 1'b1; cfg_sel = VSEL[v];
      @(negedge clk);
      cfg_we = 1'b0;
      wait_tick(n, ws);
      check(n == 63, "R4 first interval kept", n + 1, 64);
      wait_tick(n, ws);
      check(n == VGAP[v], "R1 interval period", n, VGAP[v]);
      @(negedge clk);
      check(tick == 1'b0, "R3 tick single cycle", int'(tick), 0);
    end

    // R4: mid-interval change from 512 to 64
    do_reset();
    cfg_we = 1'b1; cfg_sel = 2'b01;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_tick(n, ws);
    repeat (100) @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'b00;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_tick(n, ws);
    check(n == 512 - 101, "R4 running interval unchanged", n + 101, 512);
    wait_tick(n, ws);
    check(n == 64, "R4 new code applied", n, 64);

    // R5 / R7: watchdog fires after three ticks
    do_reset();
    wait_tick(n, ws);
    wait_tick(n, ws);
    wait_tick(n, ws);
    check(!ws && wdt == 1'b0, "R5 no early fire", int'(wdt), 0);
    @(negedge clk);
    check(wdt == 1'b1, "R5 fire after third tick", int'(wdt), 1);
    n = 1;
    while (wdt && n < 100) begin
      @(negedge clk);
      if (wdt) n++;
    end
    check(n == 4, "R7 reset hold length", n, 4);

    // R6: clear between ticks restarts the tally
    do_reset();
    wait_tick(n, ws);
    wait_tick(n, ws);
    repeat (10) @(negedge clk);
    wdt_clear = 1'b1;
    @(negedge clk);
    wdt_clear = 1'b0;
    wait_tick(n, ws);
    wait_tick(n, ws);
    @(negedge clk);
    check(!ws && wdt == 1'b0, "R6 clear restarts tally", int'(wdt), 0);
    wait_tick(n, ws);
    @(negedge clk);
    check(wdt == 1'b1, "R6 fire after three ticks past clear", int'(wdt), 1);

    // R6: clear coincident with third tick wins
    do_reset();
    wait_tick(n, ws);
    wait_tick(n, ws);
    wait_tick(n, ws);
    wdt_clear = 1'b1;
    @(negedge clk);
    wdt_clear = 1'b0;
    check(wdt == 1'b0, "R6 coincident clear wins", int'(wdt), 0);
    wait_tick(n, ws);
    wait_tick(n, ws);
    @(negedge clk);
    check(!ws && wdt == 1'b0, "R6 tick under clear not counted", int'(wdt), 0);
    wait_tick(n, ws);
    @(negedge clk);
    check(wdt == 1'b1, "R6 fire after three fresh ticks", int'(wdt), 1);

    // R9: no-buzz during sleep
    do_reset();
    sleep_active = 1'b1; no_buzz = 1'b1;
    n = 0;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (!bg) n++;
    end
    check(n == 0, "R9 bandgap forced on", n, 0);

    // R10: duty pattern for two interval codes
    for (int c = 0; c < 2; c++) begin
      int bad;
      int first_j;
      @(negedge clk);
      rst_ni = 1'b0; sleep_active = 1'b1; no_buzz = 1'b0;
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      cfg_we = 1'b1; cfg_sel = (c == 0) ? 2'b00 : 2'b11;
      bad = (bg != 1'b1) ? 1 : 0;
      first_j = -1;
      for (int j = 1; j <= 48; j++) begin
        @(negedge clk);
        cfg_we = 1'b0;
        if (bg != ((j % 16) < 2)) begin
          bad++;
          if (first_j < 0) first_j = j;
        end
      end
      check(bad == 0, "R10 duty burst pattern", first_j, -1);
    end

    // R8: awake again
    sleep_active = 1'b0;
    @(negedge clk);
    check(bg == 1'b1, "R8 bandgap when awake", int'(bg), 1);

    summary();
  end
endmodule